// File: doc/BRIEF.md
# In-Frame Response Transmit Controller

This block decides whether, when and how a node answers a finished frame with a response byte on a J1850-style bus. Software writes a three-bit response-type request and a data byte. The controller watches decoded bus events: start of frame, end of data together with the CRC verdict, bus errors, a transmit-end-of-data command and the receive side's byte-complete strobe. From these events it drives a symbol encoder through a level-based request interface. The encoder sends one normalization symbol and then eight data bits, most significant bit first.

Only the single-byte response without CRC is transmitted. The two multi-byte request bits are stored and take part in the priority encoding, but they never start a transmission. If arbitration is lost during the byte, the controller releases the bus and waits for the winning byte to finish. It then sends the same byte again, without a second normalization symbol. It keeps doing this until it succeeds or a bus error or a transmit-end-of-data command cancels the request.

Top module: `ifr_tx_ctrl`

## Requirements
- R1: The request field has bit 2 = single byte, bit 1 = multi-byte type 1 and bit 0 = multi-byte type 0. The effective request `req_eff` keeps only the highest set bit, with bit 2 ranked above bit 1 and bit 1 above bit 0. For example, 011 becomes 010 and 111 becomes 100.
- R2: `req_rd` returns the request bits as written, not the encoded value, until hardware clears bit 2.
- R3: Suppose bit 2 is effective before the cycle in which `eod_evt` arrives with `crc_ok` high. Then `tx_norm` is high from the next cycle until the encoder's `sym_done`. After that, `tx_bit_en` presents the captured byte on `tx_bit`, most significant bit first, one bit per `sym_done`, for exactly eight bits.
- R4: An `eod_evt` with `crc_ok` low starts no response and leaves the request bits unchanged.
- R5: A write to bit 2 is ignored from the cycle of `eod_evt` until the next `sof_evt`, so the bit keeps its previous value. Writes to bits 1 and 0 always take effect.
- R6: A data bit of value 1 is passive and 0 is active. If the block sends 1 and the encoder reports `sym_rx` = 0, the block drops `tx_bit_en` on the next cycle and raises `tx_abort` for one cycle. It sends no further bits, even when the loss is in one of the last two bits, until `rx_byte_done`.
- R7: After `rx_byte_done` in the waiting state, the block resends the byte captured when the response started, from its first bit and without a normalization symbol. Data register writes made in the meantime do not change it.
- R8: When all eight bits are sent without loss, `ifr_done` pulses for one cycle, bit 2 of the request clears and both transmit levels go low.
- R9: `bus_err` or `teod_set` clears bit 2 in any state. During a response they also drop the transmit levels, pulse `tx_abort`, and stop any later retry.
- R10: Requests of bits 1 or 0 alone never start a transmission, and they stay stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_we | input | 1 | Write strobe for the request field |
| req_wd | input | 3 | Request write data |
| dat_we | input | 1 | Write strobe for the response data byte |
| dat_wd | input | 8 | Response data write value |
| req_rd | output | 3 | Raw request readback |
| req_eff | output | 3 | Priority-encoded effective request |
| sof_evt | input | 1 | Start of frame seen on the bus |
| eod_evt | input | 1 | End-of-data symbol seen on the bus |
| crc_ok | input | 1 | Frame CRC valid, qualifies `eod_evt` |
| bus_err | input | 1 | Bus error detected |
| teod_set | input | 1 | Transmit-end-of-data command issued |
| rx_byte_done | input | 1 | Receive side completed a byte |
| sym_done | input | 1 | Encoder finished the requested symbol |
| sym_rx | input | 1 | Bus level sampled for that symbol |
| tx_norm | output | 1 | Request a normalization symbol |
| tx_bit_en | output | 1 | Request a data bit symbol |
| tx_bit | output | 1 | Data bit value to send |
| tx_abort | output | 1 | One-cycle pulse when driving stops early |
| ifr_done | output | 1 | One-cycle pulse on a successful response |

## Verification
The assertions assume that the encoder raises `sym_done` only while `tx_norm` or `tx_bit_en` is high, each strobe lasting one cycle. They also assume that `sym_rx` behaves as a wired-AND of the block's own bit and the competing bit. The bench keeps to this by using a bus model that pulses `sym_done` for one cycle only while a level is up, with a gap cycle after each pulse. That model answers every normalization symbol as active, and every data bit as the AND of the block's `tx_bit` and a chosen competitor byte. Events that end a frame, and cancel commands, come as single-cycle pulses, each one separate from a `sym_done` strobe.

// File: rtl/ifr_pkg.sv
package ifr_pkg;

  localparam int REQ_W      = 3;
  localparam int IDX_SINGLE = 2;
  localparam int IDX_MULTI1 = 1;
  localparam int IDX_MULTI0 = 0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NORM = 2'd1,
    ST_DATA = 2'd2,
    ST_WAIT = 2'd3
  } ifr_state_e;

  // Highest set bit wins; all lower bits are masked.
  function automatic logic [REQ_W-1:0] prio_encode(input logic [REQ_W-1:0] raw);
    logic [REQ_W-1:0] res;
    logic             found;
    res   = '0;
    found = 1'b0;
    for (int i = REQ_W - 1; i >= 0; i--) begin
      if (raw[i] && !found) begin
        res[i] = 1'b1;
        found  = 1'b1;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/ifr_req_reg.sv
module ifr_req_reg
  import ifr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_we,
  input  logic [REQ_W-1:0]  req_wd,
  input  logic              dat_we,
  input  logic [DATA_W-1:0] dat_wd,
  input  logic              sof_evt,
  input  logic              eod_evt,
  input  logic              clr_single,
  output logic [REQ_W-1:0]  req_raw,
  output logic [REQ_W-1:0]  req_eff,
  output logic [DATA_W-1:0] dat_q
);

  logic [REQ_W-1:0]  raw_q, raw_d;
  logic              raw_en;
  logic              win_q, win_d;
  logic              win_en;
  logic              blocked;
  logic [DATA_W-1:0] dat_r;

  // Post-EOD window: single-byte request writes are locked out.
  assign win_en  = eod_evt | sof_evt;
  assign win_d   = eod_evt;
  assign blocked = win_q | eod_evt;

  always_comb begin
    raw_d = raw_q;
    if (req_we) begin
      for (int i = 0; i < REQ_W; i++) begin
        if (i != IDX_SINGLE) begin
          raw_d[i] = req_wd[i];
        end else if (!blocked) begin
          raw_d[i] = req_wd[i];
        end
      end
    end
    if (clr_single) begin
      raw_d[IDX_SINGLE] = 1'b0;
    end
  end

  assign raw_en = req_we | clr_single;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else if (raw_en) begin
      raw_q <= raw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
    end else if (win_en) begin
      win_q <= win_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_r <= '0;
    end else if (dat_we) begin
      dat_r <= dat_wd;
    end
  end

  assign req_raw = raw_q;
  assign req_eff = prio_encode(raw_q);
  assign dat_q   = dat_r;

endmodule

// File: rtl/ifr_shift.sv
module ifr_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              reload,
  input  logic              shift,
  input  logic [DATA_W-1:0] data_in,
  output logic              msb,
  output logic              last
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] hold_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              sh_en;

  assign sh_en = load | reload | shift;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (load) begin
      sh_d  = data_in;
      cnt_d = '0;
    end else if (reload) begin
      sh_d  = hold_q;
      cnt_d = '0;
    end else if (shift) begin
      sh_d  = {sh_q[DATA_W-2:0], 1'b0};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (sh_en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  // Copy of the byte kept for retries after arbitration loss.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (load) begin
      hold_q <= data_in;
    end
  end

  assign msb  = sh_q[DATA_W-1];
  assign last = (cnt_q == CNT_LAST);

endmodule

// File: rtl/ifr_seq.sv
module ifr_seq
  import ifr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       single_act,
  input  logic       eod_evt,
  input  logic       crc_ok,
  input  logic       bus_err,
  input  logic       teod_set,
  input  logic       rx_byte_done,
  input  logic       sym_done,
  input  logic       sym_rx,
  input  logic       bit_msb,
  input  logic       bit_last,
  output ifr_state_e state,
  output logic       load,
  output logic       reload,
  output logic       shift,
  output logic       succ,
  output logic       abort_pulse,
  output logic       done_pulse
);

  ifr_state_e st_q, st_d;
  logic       abort_q, abort_d;
  logic       done_q;
  logic       kill;
  logic       lost;

  assign kill = bus_err | teod_set;
  assign lost = sym_done & bit_msb & ~sym_rx;

  always_comb begin
    st_d    = st_q;
    load    = 1'b0;
    reload  = 1'b0;
    shift   = 1'b0;
    succ    = 1'b0;
    abort_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (!kill && eod_evt && crc_ok && single_act) begin
          st_d = ST_NORM;
          load = 1'b1;
        end
      end
      ST_NORM: begin
        if (kill) begin
          st_d    = ST_IDLE;
          abort_d = 1'b1;
        end else if (sym_done) begin
          st_d = ST_DATA;
        end
      end
      ST_DATA: begin
        if (kill) begin
          st_d    = ST_IDLE;
          abort_d = 1'b1;
        end else if (sym_done) begin
          if (lost) begin
            st_d    = ST_WAIT;
            abort_d = 1'b1;
          end else if (bit_last) begin
            st_d = ST_IDLE;
            succ = 1'b1;
          end else begin
            shift = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (kill) begin
          st_d    = ST_IDLE;
          abort_d = 1'b1;
        end else if (rx_byte_done) begin
          st_d   = ST_DATA;
          reload = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      abort_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      abort_q <= abort_d;
      done_q  <= succ;
    end
  end

  assign state       = st_q;
  assign abort_pulse = abort_q;
  assign done_pulse  = done_q;

endmodule

// File: rtl/ifr_tx_ctrl.sv
module ifr_tx_ctrl
  import ifr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_we,
  input  logic [REQ_W-1:0]  req_wd,
  input  logic              dat_we,
  input  logic [DATA_W-1:0] dat_wd,
  output logic [REQ_W-1:0]  req_rd,
  output logic [REQ_W-1:0]  req_eff,
  input  logic              sof_evt,
  input  logic              eod_evt,
  input  logic              crc_ok,
  input  logic              bus_err,
  input  logic              teod_set,
  input  logic              rx_byte_done,
  input  logic              sym_done,
  input  logic              sym_rx,
  output logic              tx_norm,
  output logic              tx_bit_en,
  output logic              tx_bit,
  output logic              tx_abort,
  output logic              ifr_done
);

  logic [DATA_W-1:0] dat_q;
  logic              clr_single;
  logic              load, reload, shift, succ;
  logic              bit_msb, bit_last;
  ifr_state_e        state;

  assign clr_single = succ | bus_err | teod_set;

  ifr_req_reg #(.DATA_W(DATA_W)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_we     (req_we),
    .req_wd     (req_wd),
    .dat_we     (dat_we),
    .dat_wd     (dat_wd),
    .sof_evt    (sof_evt),
    .eod_evt    (eod_evt),
    .clr_single (clr_single),
    .req_raw    (req_rd),
    .req_eff    (req_eff),
    .dat_q      (dat_q)
  );

  ifr_shift #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .reload  (reload),
    .shift   (shift),
    .data_in (dat_q),
    .msb     (bit_msb),
    .last    (bit_last)
  );

  ifr_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .single_act   (req_eff[IDX_SINGLE]),
    .eod_evt      (eod_evt),
    .crc_ok       (crc_ok),
    .bus_err      (bus_err),
    .teod_set     (teod_set),
    .rx_byte_done (rx_byte_done),
    .sym_done     (sym_done),
    .sym_rx       (sym_rx),
    .bit_msb      (bit_msb),
    .bit_last     (bit_last),
    .state        (state),
    .load         (load),
    .reload       (reload),
    .shift        (shift),
    .succ         (succ),
    .abort_pulse  (tx_abort),
    .done_pulse   (ifr_done)
  );

  assign tx_norm   = (state == ST_NORM);
  assign tx_bit_en = (state == ST_DATA);
  assign tx_bit    = bit_msb & tx_bit_en;

endmodule

// File: rtl/ifr_tx_ctrl_chk.sv
module ifr_tx_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] req_rd,
  input logic [2:0] req_eff,
  input logic       eod_evt,
  input logic       crc_ok,
  input logic       bus_err,
  input logic       teod_set,
  input logic       rx_byte_done,
  input logic       sym_done,
  input logic       sym_rx,
  input logic       tx_norm,
  input logic       tx_bit_en,
  input logic       tx_bit,
  input logic       tx_abort,
  input logic       ifr_done
);

  AST_EFF_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_eff)); // R1

  AST_NORM_AFTER_EOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_norm) |-> $past(eod_evt && crc_ok)); // R3

  AST_LEVELS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_norm && tx_bit_en)); // R3

  AST_LOSS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bit_en && sym_done && tx_bit && !sym_rx && !bus_err && !teod_set)
      |=> (!tx_bit_en && tx_abort)); // R6

  AST_DATA_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_bit_en) |-> ($past(tx_norm) || $past(rx_byte_done))); // R7

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ifr_done |-> (!req_rd[2] && !tx_bit_en && !tx_norm)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ifr_done |=> !ifr_done); // R8

  AST_KILL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err || teod_set) |=> (!tx_norm && !tx_bit_en && !req_rd[2])); // R9

endmodule

bind ifr_tx_ctrl ifr_tx_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_rd       (req_rd),
  .req_eff      (req_eff),
  .eod_evt      (eod_evt),
  .crc_ok       (crc_ok),
  .bus_err      (bus_err),
  .teod_set     (teod_set),
  .rx_byte_done (rx_byte_done),
  .sym_done     (sym_done),
  .sym_rx       (sym_rx),
  .tx_norm      (tx_norm),
  .tx_bit_en    (tx_bit_en),
  .tx_bit       (tx_bit),
  .tx_abort     (tx_abort),
  .ifr_done     (ifr_done)
);

// File: tb/ifr_tx_ctrl_test.sv
module ifr_tx_ctrl_test;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       req_we;
  logic [2:0] req_wd;
  logic       dat_we;
  logic [7:0] dat_wd;
  logic [2:0] req_rd;
  logic [2:0] req_eff;
  logic       sof_evt, eod_evt, crc_ok, bus_err, teod_set, rx_byte_done;
  logic       sym_done, sym_rx;
  logic       tx_norm, tx_bit_en, tx_bit, tx_abort, ifr_done;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;

  logic [7:0] exp_q[$];
  logic [7:0] acc;
  int         acc_n     = 0;
  int         abort_cnt = 0;
  int         norm_cnt  = 0;
  int         done_cnt  = 0;

  ifr_tx_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_we(req_we), .req_wd(req_wd), .dat_we(dat_we), .dat_wd(dat_wd),
    .req_rd(req_rd), .req_eff(req_eff),
    .sof_evt(sof_evt), .eod_evt(eod_evt), .crc_ok(crc_ok),
    .bus_err(bus_err), .teod_set(teod_set), .rx_byte_done(rx_byte_done),
    .sym_done(sym_done), .sym_rx(sym_rx),
    .tx_norm(tx_norm), .tx_bit_en(tx_bit_en), .tx_bit(tx_bit),
    .tx_abort(tx_abort), .ifr_done(ifr_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // Monitor: assembles sent bits and compares against the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_norm || tx_abort) acc_n = 0;
      if (tx_abort) abort_cnt++;
      if (sym_done && tx_norm) norm_cnt++;
      if (sym_done && tx_bit_en) begin
        acc = {acc[6:0], tx_bit};
        acc_n++;
      end
      if (ifr_done) begin
        done_cnt++;
        if (exp_q.size() == 0) begin
          chk("R8 unexpected done", 1, 0);
        end else begin
          chk("R3 byte on bus", int'(acc), int'(exp_q.pop_front()));
          chk("R3 bit count", acc_n, 8);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    report();
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr_req(input logic [2:0] v);
    req_we = 1; req_wd = v; tick(); req_we = 0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    dat_we = 1; dat_wd = v; tick(); dat_we = 0;
  endtask

  task automatic p_sof();  sof_evt = 1; tick(); sof_evt = 0; endtask
  task automatic p_err();  bus_err = 1; tick(); bus_err = 0; endtask
  task automatic p_teod(); teod_set = 1; tick(); teod_set = 0; endtask
  task automatic p_rxd();  rx_byte_done = 1; tick(); rx_byte_done = 0; endtask

  task automatic p_eod(input logic ok);
    eod_evt = 1; crc_ok = ok; tick(); eod_evt = 0; crc_ok = 0;
  endtask

  // Bus model: normalization reads active; data reads wired-AND with competitor.
  task automatic bus_sym(input logic comp);
    sym_rx   = tx_norm ? 1'b0 : (tx_bit & comp);
    sym_done = 1; tick(); sym_done = 0; tick();
  endtask

  task automatic run_byte(input logic [7:0] comp);
    for (int i = 7; i >= 0; i--) begin
      if (tx_bit_en) bus_sym(comp[i]);
    end
  endtask

  task automatic expect_byte(input logic [7:0] b);
    exp_q.push_back(b);
  endtask

  task automatic arm(input logic [7:0] d);
    p_sof(); wr_dat(d); wr_req(3'b100); p_eod(1'b1);
  endtask

  initial begin
    int a0, n0;
    rst_n = 0; req_we = 0; req_wd = 0; dat_we = 0; dat_wd = 0;
    sof_evt = 0; eod_evt = 0; crc_ok = 0; bus_err = 0; teod_set = 0;
    rx_byte_done = 0; sym_done = 0; sym_rx = 1;
    repeat (3) tick();
    rst_n = 1; tick();

    chk("R8 reset tx_norm", tx_norm, 0);
    chk("R8 reset tx_bit_en", tx_bit_en, 0);
    chk("R8 reset done/abort", {ifr_done, tx_abort}, 0);
    chk("R2 reset readback", req_rd, 0);

    // R1 / R2 priority encoding and raw readback
    wr_req(3'b011);
    chk("R2 raw 011", req_rd, 3'b011);
    chk("R1 eff 011", req_eff, 3'b010);
    wr_req(3'b111);
    chk("R1 eff 111", req_eff, 3'b100);
    chk("R2 raw 111", req_rd, 3'b111);
    wr_req(3'b001);
    chk("R1 eff 001", req_eff, 3'b001);
    wr_req(3'b000);

    // R3 / R8 plain response
    expect_byte(8'hA5);
    arm(8'hA5);
    chk("R3 norm requested", tx_norm, 1);
    bus_sym(1'b1);
    chk("R3 data after norm", tx_bit_en, 1);
    run_byte(8'hFF);
    chk("R8 request cleared", req_rd, 3'b000);
    chk("R8 levels low", {tx_norm, tx_bit_en}, 0);
    chk("R8 done count", done_cnt, 1);

    // R4 CRC error: no response, request kept; R9 error in idle clears it
    p_sof(); wr_req(3'b100); p_eod(1'b0);
    chk("R4 no norm on bad CRC", tx_norm, 0);
    chk("R4 request kept", req_rd, 3'b100);
    p_err();
    chk("R9 error clears in idle", req_rd, 3'b000);

    // R5 late write after EOD ignored
    p_sof(); p_eod(1'b1);
    wr_req(3'b101);
    chk("R5 late single ignored", req_rd, 3'b001);
    tick();
    chk("R5 no response", {tx_norm, tx_bit_en}, 0);
    wr_req(3'b000);

    // R6 / R7 loss mid-byte, retry with captured byte
    expect_byte(8'h3C);
    arm(8'h3C);
    n0 = norm_cnt; a0 = abort_cnt;
    bus_sym(1'b1);
    run_byte(8'h1F);
    chk("R6 released after loss", tx_bit_en, 0);
    chk("R6 abort pulse", abort_cnt, a0 + 1);
    wr_dat(8'hFF);
    repeat (3) tick();
    chk("R6 still silent", {tx_norm, tx_bit_en}, 0);
    p_rxd();
    chk("R7 retry data", tx_bit_en, 1);
    chk("R7 retry no norm", tx_norm, 0);
    run_byte(8'hFF);
    chk("R7 single normalization", norm_cnt, n0 + 1);
    chk("R8 done after retry", done_cnt, 2);

    // R6 loss in last bit: no filler bits, then retry
    expect_byte(8'h01);
    arm(8'h01);
    bus_sym(1'b1);
    run_byte(8'h00);
    for (int k = 0; k < 4; k++) begin
      chk("R6 no filler after last-bit loss", tx_bit_en, 0);
      tick();
    end
    p_rxd();
    run_byte(8'hFF);
    chk("R7 done after last-bit retry", done_cnt, 3);

    // R9 bus error during data
    arm(8'hAA);
    bus_sym(1'b1);
    bus_sym(1'b1); bus_sym(1'b1); bus_sym(1'b1);
    a0 = abort_cnt;
    p_err();
    tick();
    chk("R9 error stops data", {tx_norm, tx_bit_en}, 0);
    chk("R9 error clears request", req_rd, 3'b000);
    chk("R9 error abort pulse", abort_cnt, a0 + 1);

    // R9 transmit-end-of-data while waiting cancels retry
    arm(8'h3C);
    bus_sym(1'b1);
    run_byte(8'h1F);
    p_teod();
    chk("R9 teod clears request", req_rd, 3'b000);
    p_rxd();
    chk("R9 no retry after teod", {tx_norm, tx_bit_en}, 0);

    // R10 multi-byte requests stored but inactive
    p_sof(); wr_req(3'b011); p_eod(1'b1);
    chk("R10 no norm for multi", tx_norm, 0);
    tick();
    chk("R10 no data for multi", tx_bit_en, 0);
    chk("R10 multi kept", req_rd, 3'b011);

    repeat (4) tick();
    chk("R8 scoreboard drained", exp_q.size(), 0);
    chk("R8 total done", done_cnt, 3);
    report();
  end

endmodule